// File: doc/BRIEF.md
# Scan-Testable Binary Up-Counter

This block is a small synchronous binary up-counter whose state flops are built as multiplexed-D scan cells. In functional operation it adds one on each clock while its count enable is high, keeps its value while the enable is low, and wraps from all ones back to zero. A synchronous clear forces every bit to zero.

Raising the shift-mode select turns the same flops into one serial shift path. Bits go in at the serial input, move one position toward the most significant bit on each clock, and leave at the serial output, which is tied to the top bit. A test can therefore shift in any state, drop the select for one functional clock so the next state is captured, and then shift that result out for comparison. The counter width is a parameter and defaults to three bits.

Top module: `scan_up_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, every bit of `count_o` is 0 after that edge, whatever `cnt_en`, `shift_en` and `shift_in` are.
- R2: With `clr` and `shift_en` low and `cnt_en` high, `count_o` (bit 0 is the least significant) rises by exactly one at each rising edge.
- R3: A count step from all ones (7 at the default width) gives 0 at the next edge.
- R4: With `clr`, `shift_en` and `cnt_en` all low, `count_o` keeps its value across the edge.
- R5: With `shift_en` high and `clr` low, each edge moves `shift_in` into bit 0 and bit i-1 into bit i. `cnt_en` has no effect in this mode.
- R6: `shift_out` always equals the most significant bit of `count_o`.
- R7: A value V loaded by shifting in V[2], then V[1], then V[0] over three shift edges appears on `count_o` as V. Three further shift edges then present V[2], V[1] and V[0] on `shift_out`, in that order, each read just before its edge.
- R8: After a state is loaded by shifting, one functional edge with `cnt_en` high leaves the incremented state (for example 3 becomes 4, with the carry setting bit 2), and shifting that state out returns the incremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| cnt_en | input | 1 | Count enable in functional mode |
| shift_en | input | 1 | High selects the serial shift path |
| shift_in | input | 1 | Serial data into bit 0 |
| count_o | output | WIDTH | Present counter state |
| shift_out | output | 1 | Serial data out, the top state bit |

## Verification
The assertions assume the block has seen at least one clear before its state means anything, so the checks on shifting, counting and holding stay off until two edges after the first `clr`. They also assume the inputs are stable around the rising edge. The bench drives every input on the falling edge and starts each run with a clear. It toggles `cnt_en` during shifting on purpose, to show that this input has no effect in shift mode.

// File: rtl/scan_count_pkg.sv
package scan_count_pkg;

  // Per-cell operation selected for one clock edge
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_SHIFT = 2'd1,
    OP_FUNC  = 2'd2
  } cell_op_e;

  // Clear dominates, then shift mode, else the functional next state
  function automatic cell_op_e pick_op(input logic clr, input logic shift_sel);
    if (clr)            return OP_CLEAR;
    else if (shift_sel) return OP_SHIFT;
    else                return OP_FUNC;
  endfunction

endpackage

// File: rtl/scan_count_logic.sv
module scan_count_logic #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] next_o,
  output logic             carry_o
);

  // AND/XOR ripple: bit i toggles when enable and all lower bits are set
  function automatic logic [WIDTH:0] ripple_step(input logic [WIDTH-1:0] s,
                                                 input logic en);
    logic [WIDTH:0] r;
    logic           c;
    c = en;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = s[i] ^ c;
      c    = c & s[i];
    end
    r[WIDTH] = c;
    return r;
  endfunction

  logic [WIDTH:0] step_w;

  assign step_w  = ripple_step(state_i, en_i);
  assign next_o  = step_w[WIDTH-1:0];
  assign carry_o = step_w[WIDTH];

endmodule

// File: rtl/scan_mux_cell.sv
module scan_mux_cell
  import scan_count_pkg::*;
(
  input  logic     clk,
  input  cell_op_e op_i,
  input  logic     func_d_i,
  input  logic     scan_d_i,
  output logic     q_o
);

  always_ff @(posedge clk) begin
    unique case (op_i)
      OP_CLEAR: q_o <= 1'b0;
      OP_SHIFT: q_o <= scan_d_i;
      default:  q_o <= func_d_i;
    endcase
  end

endmodule

// File: rtl/scan_up_counter.sv
module scan_up_counter
  import scan_count_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] count_o,
  output logic             shift_out
);

  localparam int TOP = WIDTH - 1;

  cell_op_e         op_w;
  logic [WIDTH-1:0] func_next_w;
  logic [WIDTH-1:0] scan_next_w;
  logic             carry_w;
  logic             wrap_evt;   // functional count step out of all ones
  logic             shift_evt;  // edge performs a shift

  assign op_w = pick_op(clr, shift_en);

  scan_count_logic #(.WIDTH(WIDTH)) next_i (
    .state_i (count_o),
    .en_i    (cnt_en),
    .next_o  (func_next_w),
    .carry_o (carry_w)
  );

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_cell
      if (g == 0) begin : g_head
        assign scan_next_w[g] = shift_in;
      end else begin : g_link
        assign scan_next_w[g] = count_o[g-1];
      end
      scan_mux_cell cell_i (
        .clk      (clk),
        .op_i     (op_w),
        .func_d_i (func_next_w[g]),
        .scan_d_i (scan_next_w[g]),
        .q_o      (count_o[g])
      );
    end
  endgenerate

  assign shift_out = count_o[TOP];

  assign wrap_evt  = (op_w == OP_FUNC) && carry_w;
  assign shift_evt = (op_w == OP_SHIFT);

  // Assertion qualifiers: state is defined only after a clear has landed
  logic armed_q  = 1'b0;
  logic armed2_q = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed_q <= 1'b1;
    armed2_q <= armed_q;
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!armed_q)
    clr |=> (count_o == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (clr || !armed2_q)
    (!shift_en && cnt_en) |=> (count_o == WIDTH'($past(count_o) + 1'b1))); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (clr || !armed2_q)
    wrap_evt |=> (count_o == '0)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr || !armed2_q)
    (!shift_en && !cnt_en) |=> $stable(count_o)); // R4

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (clr || !armed2_q)
    shift_evt |=> (count_o == {$past(count_o[TOP-1:0]), $past(shift_in)})); // R5

  AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (clr || !armed2_q)
    shift_evt |=> (shift_out == $past(count_o[TOP-1]))); // R6

endmodule

// File: tb/scan_up_counter_tb.sv
module scan_up_counter_tb_top;

  localparam int W = 3;
  localparam int WATCHDOG_NS = 200000;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         cnt_en = 1'b0;
  logic         shift_en = 1'b0;
  logic         shift_in = 1'b0;
  logic [W-1:0] count_o;
  logic         shift_out;

  int checks = 0;
  int failures = 0;
  int mdl = 0;   // behavioural model of the state, as an integer

  always #10 clk = ~clk;   // 50 MHz

  scan_up_counter #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .clr       (clr),
    .cnt_en    (cnt_en),
    .shift_en  (shift_en),
    .shift_in  (shift_in),
    .count_o   (count_o),
    .shift_out (shift_out)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, advance the model, then compare one edge later
  task automatic cyc(input logic c, input logic e, input logic s, input logic i,
                     input string tag);
    clr = c; cnt_en = e; shift_en = s; shift_in = i;
    if (c)      mdl = 0;
    else if (s) mdl = ((mdl * 2) + int'(i)) % (1 << W);
    else if (e) mdl = (mdl + 1) % (1 << W);
    @(negedge clk);
    check(int'(count_o), mdl, tag);
    check(int'(shift_out), (mdl >> (W - 1)) & 1, "R6");
  endtask

  task automatic load(input int v, input logic en_noise);
    for (int b = W - 1; b >= 0; b--) cyc(1'b0, en_noise, 1'b1, v[b], "R5");
    check(int'(count_o), v, "R7 load");
  endtask

  task automatic unload(input int exp, input string tag);
    int got = 0;
    for (int b = W - 1; b >= 0; b--) begin
      got[b] = shift_out;
      cyc(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    end
    check(got, exp, tag);
  endtask

  initial begin
    #(WATCHDOG_NS * 1ns);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: clear from unknown state
    cyc(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    // R2 and R3: ten counting edges pass through 7 -> 0
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R2/R3");
    // R4: hold
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1, "R4");
    // R1: clear wins over counting and over shifting
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R1 over count");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, "R5");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, "R1 over shift");
    // R5 and R7: load every value with enable noise, read it back serially
    for (int v = 0; v < (1 << W); v++) begin
      load(v, v[0]);
      unload(v, "R7 unload");
    end
    // R8: capture after a shifted load
    for (int v = 0; v < (1 << W); v++) begin
      load(v, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, "R8 capture");
      unload((v + 1) % (1 << W), "R8 unload");
    end
    // R4 under capture: enable low leaves the loaded state
    load(5, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R4 capture hold");
    unload(5, "R4 unload");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule